// File: doc/BRIEF.md
# Profile-Based Trim Code Selector

This block picks the 8-bit code that each of several trim DAC channels receives. A 2-bit profile input is shared by all channels. It chooses one of four operating profiles. Profiles one to three always take a fixed preset code from the channel's configuration. Profile zero is a second-level choice made separately for each channel by a 2-bit mode field. In that profile the code comes from a fixed preset, from a volatile register that a host writes, or from a closed-loop trim register.

The closed-loop register can be loaded in two ways. A trim engine outside the block loads it through a per-channel update strobe. The host can also load it by writing to the same address it uses for the host register. The channel's profile-zero mode decides which of the two registers a host write reaches. Codes are 7-bit-plus-sign bipolar values, and 80h is the zero point. For each channel the block also reports whether that channel is currently being driven by closed-loop trim. Presets and mode fields are plain configuration inputs.

Top module: `trim_code_sel`

## Requirements
- R1: When the synchronized profile is 01, 10 or 11, every channel outputs its preset 1, 2 or 3 respectively, whatever its mode. Preset k of channel c sits at `preset_cfg[(c*4+k)*8 +: 8]`.
- R2: When the synchronized profile is 00 and the channel mode is 00 (fixed) or 11 (reserved, handled as fixed), the channel outputs its preset 0.
- R3: When the synchronized profile is 00 and the channel mode is 01, the channel outputs its host register.
- R4: When the synchronized profile is 00 and the channel mode is 10, the channel outputs its closed-loop register.
- R5: While reset is low, and on the first edges after it is released, the host and closed-loop registers of every channel hold 80h, `dac_code` reads 80h on every channel, `loop_active` is 0 and the synchronized profile is 00.
- R6: A host write (`host_we`, channel `host_ch`, mode field `p0_mode[c*2 +: 2]`) goes to the closed-loop register when that channel's mode is 10, and to the host register otherwise. Other channels are untouched. A write whose channel index is NCH or above changes nothing.
- R7: `loop_we[c]` loads `loop_data[c*8 +: 8]` into channel c's closed-loop register. If a host write reaches the same closed-loop register in the same cycle, the host data wins.
- R8: `loop_active[c]` is 1 exactly when the synchronized profile was 00 and channel c's mode was 10 on the previous edge.
- R9: `prof_sel` passes through a two-flop synchronizer, and the output register adds one more stage, so a profile change shows on `dac_code` after the third rising edge. A register write shows after the second edge. A change to a preset or mode input shows after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_sel | input | 2 | Shared profile select, asynchronous |
| preset_cfg | input | NCH*4*8 | Presets 0..3 per channel |
| p0_mode | input | NCH*2 | Profile-zero mode per channel: 00 fixed, 01 host, 10 loop, 11 fixed |
| host_we | input | 1 | Host write strobe |
| host_ch | input | CHW | Host write channel index |
| host_data | input | 8 | Host write data |
| loop_we | input | NCH | Closed-loop update strobe per channel |
| loop_data | input | NCH*8 | Closed-loop update code per channel |
| dac_code | output | NCH*8 | Registered DAC code per channel |
| loop_active | output | NCH | Channel is under active closed-loop trim |

## Verification
The hardest case to reach from the ports is a host write and a trim-engine update hitting the same closed-loop register in the same cycle, because the result only becomes visible after the profile and mode route that register to the output. The stimulus first puts every channel in loop mode with profile zero selected. It then raises `loop_we` together with a host write to the same channel and to a different channel, and also issues writes to out-of-range channel indices. After that it cycles the profile with single-cycle pulses to exercise the synchronizer latency, and applies a reset in the middle of the run.

// File: rtl/trim_code_sel.sv
module trim_code_sel #(
  parameter int NCH = 6,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            prof_sel,
  input  logic [NCH*4*CW-1:0]   preset_cfg,
  input  logic [NCH*2-1:0]      p0_mode,
  input  logic                  host_we,
  input  logic [CHW-1:0]        host_ch,
  input  logic [CW-1:0]         host_data,
  input  logic [NCH-1:0]        loop_we,
  input  logic [NCH*CW-1:0]     loop_data,
  output logic [NCH*CW-1:0]     dac_code,
  output logic [NCH-1:0]        loop_active
);
  localparam logic [CW-1:0] BPZ = CW'(1) << (CW - 1);

  logic [1:0]    sel_s1, sel_s2;
  logic [CW-1:0] host_q [NCH];
  logic [CW-1:0] loop_q [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_s1 <= 2'b00;
      sel_s2 <= 2'b00;
    end else begin
      sel_s1 <= prof_sel;
      sel_s2 <= sel_s1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0]    mode;
    logic          hit;
    logic [CW-1:0] nxt, code_q;
    logic          act_q;

    assign mode = p0_mode[c*2 +: 2];
    assign hit  = host_we && (host_ch == CHW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        host_q[c] <= BPZ;
        loop_q[c] <= BPZ;
      end else begin
        if (hit && mode != 2'b10) host_q[c] <= host_data;
        if (hit && mode == 2'b10) loop_q[c] <= host_data;
        else if (loop_we[c])      loop_q[c] <= loop_data[c*CW +: CW];
      end
    end

    always_comb begin
      case (sel_s2)
        2'b01:   nxt = preset_cfg[(c*4+1)*CW +: CW];
        2'b10:   nxt = preset_cfg[(c*4+2)*CW +: CW];
        2'b11:   nxt = preset_cfg[(c*4+3)*CW +: CW];
        default: begin
          case (mode)
            2'b01:   nxt = host_q[c];
            2'b10:   nxt = loop_q[c];
            default: nxt = preset_cfg[(c*4)*CW +: CW];
          endcase
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q <= BPZ;
        act_q  <= 1'b0;
      end else begin
        code_q <= nxt;
        act_q  <= (sel_s2 == 2'b00) && (mode == 2'b10);
      end
    end

    assign dac_code[c*CW +: CW] = code_q;
    assign loop_active[c]       = act_q;
  end
endmodule

// File: rtl/trim_code_sel_chk.sv
module trim_code_sel_chk #(
  parameter int NCH = 6,
  parameter int CW  = 8,
  parameter int CHW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          prof_sel,
  input logic [1:0]          sel_s1,
  input logic [1:0]          sel_s2,
  input logic [NCH*4*CW-1:0] preset_cfg,
  input logic [NCH*2-1:0]    p0_mode,
  input logic                host_we,
  input logic [CHW-1:0]      host_ch,
  input logic [CW-1:0]       host_data,
  input logic [NCH-1:0]      loop_we,
  input logic [NCH*CW-1:0]   loop_data,
  input logic [CW-1:0]       host_q [NCH],
  input logic [CW-1:0]       loop_q [NCH],
  input logic [NCH*CW-1:0]   dac_code,
  input logic [NCH-1:0]      loop_active
);
  assert_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> sel_s2 == $past(prof_sel, 2));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    assert_prof1_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s2 == 2'b01) |=> dac_code[c*CW +: CW] == $past(preset_cfg[(c*4+1)*CW +: CW]));
    assert_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s2 == 2'b00 && (p0_mode[c*2 +: 2] == 2'b00 || p0_mode[c*2 +: 2] == 2'b11))
      |=> dac_code[c*CW +: CW] == $past(preset_cfg[(c*4)*CW +: CW]));
    assert_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s2 == 2'b00 && p0_mode[c*2 +: 2] == 2'b01) |=> dac_code[c*CW +: CW] == $past(host_q[c]));
    assert_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s2 == 2'b00 && p0_mode[c*2 +: 2] == 2'b10) |=> dac_code[c*CW +: CW] == $past(loop_q[c]));
    assert_hostwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_ch == CHW'(c) && p0_mode[c*2 +: 2] != 2'b10) |=> host_q[c] == $past(host_data));
    assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_ch == CHW'(c) && p0_mode[c*2 +: 2] == 2'b10 && loop_we[c])
      |=> loop_q[c] == $past(host_data));
    assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      loop_active[c] |-> ($past(sel_s2) == 2'b00 && $past(p0_mode[c*2 +: 2]) == 2'b10));
  end
endmodule

bind trim_code_sel trim_code_sel_chk #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .sel_s1(sel_s1), .sel_s2(sel_s2),
  .preset_cfg(preset_cfg), .p0_mode(p0_mode), .host_we(host_we), .host_ch(host_ch),
  .host_data(host_data), .loop_we(loop_we), .loop_data(loop_data), .host_q(host_q),
  .loop_q(loop_q), .dac_code(dac_code), .loop_active(loop_active)
);

// File: tb/trim_code_sel_test.sv
module trim_code_sel_test;
  localparam int NCH = 6;
  localparam int CW  = 8;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [1:0]        prof_sel = 0;
  logic [NCH*4*CW-1:0] preset_cfg = '0;
  logic [NCH*2-1:0]  p0_mode = '0;
  logic              host_we = 0;
  logic [2:0]        host_ch = 0;
  logic [CW-1:0]     host_data = 0;
  logic [NCH-1:0]    loop_we = 0;
  logic [NCH*CW-1:0] loop_data = '0;
  logic [NCH*CW-1:0] dac_code;
  logic [NCH-1:0]    loop_active;

  trim_code_sel #(.NCH(NCH), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .preset_cfg(preset_cfg),
    .p0_mode(p0_mode), .host_we(host_we), .host_ch(host_ch), .host_data(host_data),
    .loop_we(loop_we), .loop_data(loop_data), .dac_code(dac_code), .loop_active(loop_active)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0;
  string phase = "R5";
  int m_host [NCH], m_loop [NCH], m_code [NCH], m_act [NCH];
  string m_tag [NCH];
  int m_s1 = 0, m_s2 = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_host[c] = 128; m_loop[c] = 128; m_code[c] = 128; m_act[c] = 0; m_tag[c] = "R5";
      end
      m_s1 = 0; m_s2 = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int md;
        md = p0_mode[c*2 +: 2];
        if (m_s2 != 0) begin
          m_code[c] = preset_cfg[(c*4+m_s2)*CW +: CW]; m_tag[c] = "R1";
        end else if (md == 1) begin
          m_code[c] = m_host[c]; m_tag[c] = "R3";
        end else if (md == 2) begin
          m_code[c] = m_loop[c]; m_tag[c] = "R4";
        end else begin
          m_code[c] = preset_cfg[(c*4)*CW +: CW]; m_tag[c] = "R2";
        end
        m_act[c] = (m_s2 == 0 && md == 2) ? 1 : 0;
      end
      for (int c = 0; c < NCH; c++) begin
        int md;
        bit hit;
        md = p0_mode[c*2 +: 2];
        hit = host_we && (int'(host_ch) == c);
        if (hit && md != 2) m_host[c] = host_data;
        if (hit && md == 2) m_loop[c] = host_data;
        else if (loop_we[c]) m_loop[c] = loop_data[c*CW +: CW];
      end
      m_s2 = m_s1; m_s1 = prof_sel;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      for (int c = 0; c < NCH; c++) begin
        n_chk++;
        if (int'(dac_code[c*CW +: CW]) != m_code[c]) begin
          n_fail++;
          $display("FAIL %s/%s ch%0d code actual %0h expected %0h", m_tag[c], phase, c,
                   dac_code[c*CW +: CW], m_code[c]);
        end
        n_chk++;
        if (int'(loop_active[c]) != m_act[c]) begin
          n_fail++;
          $display("FAIL R8/%s ch%0d flag actual %0d expected %0d", phase, c, loop_active[c], m_act[c]);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_presets(int seed);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++)
        preset_cfg[(c*4+k)*CW +: CW] = 8'(seed + c*13 + k*37);
  endtask

  task automatic all_modes(logic [1:0] m);
    for (int c = 0; c < NCH; c++) p0_mode[c*2 +: 2] = m;
  endtask

  task automatic hwrite(int ch, int d);
    host_we = 1; host_ch = 3'(ch); host_data = 8'(d);
    tick(1);
    host_we = 0;
  endtask

  initial begin
    set_presets(5);
    tick(5);
    rst_n = 1; tick(3);

    phase = "R2";
    p0_mode = 12'b11_00_11_00_11_00;
    tick(4);
    set_presets(77); tick(2);

    phase = "R1";
    p0_mode = 12'b10_01_00_11_10_01;
    prof_sel = 2'b01; tick(5);
    prof_sel = 2'b10; tick(5);
    prof_sel = 2'b11; tick(5);
    set_presets(200); tick(3);
    prof_sel = 2'b00; tick(4);

    phase = "R3";
    all_modes(2'b01);
    for (int c = 0; c < NCH; c++) hwrite(c, 8'h20 + c*9);
    hwrite(6, 8'hEE); hwrite(7, 8'hDD);
    tick(3);

    phase = "R6";
    p0_mode[2*2 +: 2] = 2'b10;
    hwrite(2, 8'h3C);
    tick(2);
    p0_mode[2*2 +: 2] = 2'b01; tick(2);
    all_modes(2'b10); tick(2);
    hwrite(4, 8'h91); hwrite(7, 8'h11); tick(2);
    all_modes(2'b01); tick(2);

    phase = "R7";
    all_modes(2'b10);
    for (int c = 0; c < NCH; c++) loop_data[c*CW +: CW] = 8'(8'h40 + c*5);
    loop_we = 6'b111111; tick(1); loop_we = 0; tick(2);
    for (int c = 0; c < NCH; c++) loop_data[c*CW +: CW] = 8'(8'hA0 + c);
    loop_we = 6'b000110; host_we = 1; host_ch = 3'd1; host_data = 8'h5A;
    tick(1); loop_we = 0; host_we = 0; tick(2);
    loop_we = 6'b100000; host_we = 1; host_ch = 3'd6; host_data = 8'h66;
    tick(1); loop_we = 0; host_we = 0; tick(3);

    phase = "R8";
    p0_mode = 12'b10_00_10_01_10_11;
    tick(2);
    prof_sel = 2'b01; tick(4);
    prof_sel = 2'b00; tick(4);

    phase = "R9";
    for (int i = 0; i < 8; i++) begin
      prof_sel = 2'(i); tick(1);
      p0_mode = 12'(i * 12'h2B7);
      if (i % 3 == 0) hwrite(i % NCH, 8'hC0 + i);
    end
    prof_sel = 2'b00; tick(5);

    phase = "R5";
    rst_n = 0; tick(3); rst_n = 1; tick(2);
    all_modes(2'b01); tick(3);
    all_modes(2'b10); tick(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule